// File: doc/BRIEF.md
# Rotation Parameter Line Stepper

This block holds the per-scanline starting state for two independent rotation parameter sets. At the start of each displayed line it walks a parameter table in video memory through a simple word-read port. The table holds one 48-word record per set, and the second record sits 64 words above the first. After a record is in, the block either reloads or advances three 32-bit accumulators for that set: the X start, the Y start and the coefficient address. It also latches the decoded static fields of the record, such as the matrix, the viewpoint, the center and the scale values. Both the accumulators and the static fields drive the downstream per-pixel logic.

Software selects what is reloaded on the next line with a small control register: three bits per set. These bits clear themselves once a fetch begins. On line 0 every bit of both sets is forced on for that fetch. While the table walk is in progress the block holds `busy` high. Once `busy` falls, all outputs hold the results for the new line.

Top module: `rot_line_stepper`

## Requirements
- R1: A fetch starts on a `line_start` pulse only when `line_active` is 1, `blank_int` is 0, `layer_en[4]` or `layer_en[5]` is 1, and `busy` is 0. Any other pulse leaves `busy`, `mem_req` and every output unchanged.
- R2: The record base is `tbl_base & 0x7FFBE`. Set 0 reads words base+0 to base+47 and set 1 reads words base+64 to base+111, each address taken modulo 2^18 on `mem_addr`.
- R3: `mem_req` stays high with `mem_addr` stable until a cycle with `mem_valid` high. That cycle accepts `mem_rdata` as one word. A full fetch accepts exactly 96 words, set 0 first.
- R4: Static field f of set s appears sign-extended on `static_o[(s*20+f)*32 +: 32]`. A 32-bit pair at word offset o is {word o, word o+1}. The fields are: 0 Zst, pair 4, bits 28:6. 1 DX, pair 10, bits 18:6. 2 DY, pair 12, bits 18:6. 3..8 matrix elements, pairs 14,16,..,24, bits 19:6. 9..11 Px/Py/Pz, words 26..28, bits 13:0. 12..14 Cx/Cy/Cz, words 30..32, bits 13:0. 15/16 Mx/My, pairs 34/36, bits 29:6. 17/18 kx/ky, pairs 38/40, bits 23:0. 19 per-pixel coefficient delta, pair 46, bits 25:6.
- R5: When control bit 0 of a set is 1, X start (`x_acc_o`) loads the signed value in bits 28:6 of pair 0. When it is 0, X start adds the signed value in bits 18:6 of pair 6.
- R6: Control bit 1 does the same for Y start (`y_acc_o`), using pair 2 and delta pair 8.
- R7: When control bit 2 is 1, the coefficient accumulator (`k_acc_o`) loads (coef offset << 26) + bits 31:6 of pair 42, unsigned. When it is 0, it adds the signed value in bits 25:6 of pair 44. Set 0 uses `coef_ofs[2:0]` and set 1 uses `coef_ofs[5:3]`.
- R8: When `line_zero` is 1 with the accepted pulse, all three bits of both sets act as 1 for that fetch, whatever the control register holds.
- R9: The control register (`ctl_wdata[2:0]` for set 0, `ctl_wdata[5:3]` for set 1) clears in the cycle a fetch starts, after its value has been captured for that fetch. A write in that same cycle takes effect for the next line.
- R10: `busy` rises at the edge that accepts the pulse. It falls at the edge that updates set 1. Pulses seen while `busy` is high start nothing.
- R11: Reset clears all accumulators and static fields to 0, and accumulator sums wrap modulo 2^32.
- R12: While `busy` stays low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Pulse at the start of the horizontal active phase |
| line_active | input | 1 | Current line lies in the vertical active region |
| line_zero | input | 1 | Current line is line 0 |
| blank_int | input | 1 | Display internally blanked |
| layer_en | input | 6 | Layer enables; bits 4 and 5 are the rotation layers |
| tbl_base | input | 19 | Parameter table base, word address |
| ctl_we | input | 1 | Write strobe for the reload-control register |
| ctl_wdata | input | 6 | Reload bits, set 0 in 2:0 and set 1 in 5:3 (X, Y, coefficient) |
| coef_ofs | input | 6 | Coefficient table offsets, set 0 in 2:0 and set 1 in 5:3 |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 18 | Word address of the request |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Table walk in progress |
| x_acc_o | output | 64 | X start accumulators, set s at [s*32 +: 32] |
| y_acc_o | output | 64 | Y start accumulators |
| k_acc_o | output | 64 | Coefficient address accumulators |
| static_o | output | 1280 | Decoded static fields, 20 per set, 32 bits each |

## Verification
`busy` reads 1 one edge after an accepted `line_start` pulse. The bench samples 3 ns after each rising edge, so it sees that value on the first sample after the pulse. All outputs are final at the edge where `busy` falls, because set 1 commits there. The bench polls `busy` away from the edge and compares every output only once `busy` has gone low. The memory model answers on falling edges with a latency of 0 to 2 cycles. It logs each address as it raises `mem_valid`, so the word count and the record start addresses can be checked after the walk.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned TBL_WORDS = 48;
  localparam int unsigned TBL_BITS  = TBL_WORDS * WORD_W;
  localparam int unsigned NFIELD    = 20;
  localparam int unsigned CTL_W     = 3;

  // word offsets of fields used by the accumulators
  localparam int unsigned OFS_XST  = 0;
  localparam int unsigned OFS_YST  = 2;
  localparam int unsigned OFS_DXST = 6;
  localparam int unsigned OFS_DYST = 8;
  localparam int unsigned OFS_KST  = 42;
  localparam int unsigned OFS_DKST = 44;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_COMMIT} walk_state_t;

  function automatic logic [15:0] pick_word(input logic [TBL_BITS-1:0] tb, input int unsigned ofs);
    return tb[ofs*WORD_W +: WORD_W];
  endfunction

  // big-endian pair: lower offset supplies the upper half
  function automatic logic [31:0] pick_pair(input logic [TBL_BITS-1:0] tb, input int unsigned ofs);
    return {tb[ofs*WORD_W +: WORD_W], tb[(ofs+1)*WORD_W +: WORD_W]};
  endfunction

  // signed field of width w starting at bit sh, sign-extended to 32 bits
  function automatic logic [31:0] sx_field(input logic [31:0] raw, input int unsigned sh,
                                           input int unsigned w);
    logic [31:0] t;
    t = raw << (32 - sh - w);
    return $unsigned($signed(t) >>> (32 - w));
  endfunction

  function automatic logic [31:0] step_xy(input logic [31:0] acc, input logic reload,
                                          input logic [31:0] start_raw, input logic [31:0] delta_raw);
    return reload ? sx_field(start_raw, 6, 23) : acc + sx_field(delta_raw, 6, 13);
  endfunction

  function automatic logic [31:0] step_coef(input logic [31:0] acc, input logic reload,
                                            input logic [2:0] ofs, input logic [31:0] start_raw,
                                            input logic [31:0] delta_raw);
    return reload ? ({3'b000, ofs, 26'd0} + {6'd0, start_raw[31:6]})
                  : acc + sx_field(delta_raw, 6, 20);
  endfunction

  function automatic logic [31:0] decode_static(input logic [TBL_BITS-1:0] tb, input int unsigned f);
    logic [31:0] r;
    if (f == 0)       r = sx_field(pick_pair(tb, 4), 6, 23);
    else if (f == 1)  r = sx_field(pick_pair(tb, 10), 6, 13);
    else if (f == 2)  r = sx_field(pick_pair(tb, 12), 6, 13);
    else if (f <= 8)  r = sx_field(pick_pair(tb, 14 + 2*(f-3)), 6, 14);
    else if (f <= 11) r = sx_field({pick_word(tb, 26 + (f-9)), 16'h0000}, 16, 14);
    else if (f <= 14) r = sx_field({pick_word(tb, 30 + (f-12)), 16'h0000}, 16, 14);
    else if (f <= 16) r = sx_field(pick_pair(tb, 34 + 2*(f-15)), 6, 24);
    else if (f <= 18) r = sx_field(pick_pair(tb, 38 + 2*(f-17)), 0, 24);
    else              r = sx_field(pick_pair(tb, 46), 6, 20);
    return r;
  endfunction
endpackage

// File: rtl/rls_fetch_ctrl.sv
module rls_fetch_ctrl
  import rls_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned NSETS      = 2,
  parameter int unsigned SET_STRIDE = 64,
  parameter int unsigned NWORDS     = TBL_WORDS,
  parameter int unsigned WIDX_W     = $clog2(NWORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [ADDR_W:0]     tbl_base,
  input  logic                mem_valid,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                busy,
  output logic                word_we,
  output logic [WIDX_W-1:0]   word_idx,
  output logic [NSETS-1:0]    set_commit
);
  localparam int unsigned SIDX_W = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam logic [ADDR_W:0] BASE_MASK = ~((ADDR_W+1)'(SET_STRIDE)) & ~((ADDR_W+1)'(1));
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NWORDS - 1);
  localparam logic [SIDX_W-1:0] LAST_S = SIDX_W'(NSETS - 1);

  walk_state_t        state_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [SIDX_W-1:0]  sidx_q;
  logic [ADDR_W:0]    base_q;
  logic [ADDR_W:0]    addr_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      sidx_q  <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_FETCH;
          widx_q  <= '0;
          sidx_q  <= '0;
          base_q  <= tbl_base & BASE_MASK;
        end
        ST_FETCH: if (mem_valid) begin
          if (widx_q == LAST_W) state_q <= ST_COMMIT;
          else                  widx_q  <= widx_q + 1'b1;
        end
        ST_COMMIT: begin
          widx_q <= '0;
          if (sidx_q == LAST_S) state_q <= ST_IDLE;
          else begin
            sidx_q  <= sidx_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_sum = base_q + (ADDR_W+1)'(int'(sidx_q) * SET_STRIDE) + (ADDR_W+1)'(widx_q);
  assign mem_addr = addr_sum[ADDR_W-1:0];
  assign mem_req  = (state_q == ST_FETCH);
  assign busy     = (state_q != ST_IDLE);
  assign word_we  = mem_req && mem_valid;
  assign word_idx = widx_q;

  for (genvar s = 0; s < NSETS; s++) begin : g_commit
    assign set_commit[s] = (state_q == ST_COMMIT) && (sidx_q == SIDX_W'(s));
  end
endmodule

// File: rtl/rls_word_buf.sv
module rls_word_buf
  import rls_pkg::*;
#(
  parameter int unsigned NWORDS = TBL_WORDS,
  parameter int unsigned WIDX_W = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [WIDX_W-1:0]          idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [NWORDS*WORD_W-1:0]   flat
);
  logic [WORD_W-1:0] w_q [NWORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) w_q[i] <= '0;
    end else if (we && (idx < WIDX_W'(NWORDS))) begin
      w_q[idx] <= wdata;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_flat
    assign flat[i*WORD_W +: WORD_W] = w_q[i];
  end
endmodule

// File: rtl/rls_set_regs.sv
module rls_set_regs
  import rls_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [CTL_W-1:0]       reload,
  input  logic [2:0]             coef_ofs,
  input  logic [TBL_BITS-1:0]    tb,
  output logic [31:0]            x_q,
  output logic [31:0]            y_q,
  output logic [31:0]            k_q,
  output logic [NFIELD*32-1:0]   stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      k_q <= '0;
    end else if (commit) begin
      x_q <= step_xy(x_q, reload[0], pick_pair(tb, OFS_XST), pick_pair(tb, OFS_DXST));
      y_q <= step_xy(y_q, reload[1], pick_pair(tb, OFS_YST), pick_pair(tb, OFS_DYST));
      k_q <= step_coef(k_q, reload[2], coef_ofs, pick_pair(tb, OFS_KST), pick_pair(tb, OFS_DKST));
    end
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)      stat_q[f*32 +: 32] <= '0;
      else if (commit) stat_q[f*32 +: 32] <= decode_static(tb, f);
    end
  end
endmodule

// File: rtl/rot_line_stepper.sv
module rot_line_stepper
  import rls_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned NSETS      = 2,
  parameter int unsigned SET_STRIDE = 64,
  parameter int unsigned LAYER_W    = 6,
  parameter int unsigned ROT_LAYER0 = 4,
  parameter int unsigned ROT_LAYER1 = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_start,
  input  logic                        line_active,
  input  logic                        line_zero,
  input  logic                        blank_int,
  input  logic [LAYER_W-1:0]          layer_en,
  input  logic [ADDR_W:0]             tbl_base,
  input  logic                        ctl_we,
  input  logic [NSETS*CTL_W-1:0]      ctl_wdata,
  input  logic [NSETS*3-1:0]          coef_ofs,
  output logic                        mem_req,
  output logic [ADDR_W-1:0]           mem_addr,
  input  logic                        mem_valid,
  input  logic [WORD_W-1:0]           mem_rdata,
  output logic                        busy,
  output logic [NSETS*32-1:0]         x_acc_o,
  output logic [NSETS*32-1:0]         y_acc_o,
  output logic [NSETS*32-1:0]         k_acc_o,
  output logic [NSETS*NFIELD*32-1:0]  static_o
);
  localparam int unsigned WIDX_W = $clog2(TBL_WORDS);
  localparam int unsigned CTL_BITS = NSETS * CTL_W;

  logic                  fetch_go;
  logic                  word_we;
  logic [WIDX_W-1:0]     word_idx;
  logic [NSETS-1:0]      set_commit;
  logic [TBL_BITS-1:0]   tb_flat;
  logic [CTL_BITS-1:0]   ctl_q;
  logic [CTL_BITS-1:0]   ctl_snap_q;

  assign fetch_go = line_start && line_active && !blank_int && !busy &&
                    (layer_en[ROT_LAYER0] || layer_en[ROT_LAYER1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      ctl_snap_q <= '0;
    end else begin
      if (fetch_go) ctl_snap_q <= line_zero ? '1 : ctl_q;
      if (ctl_we)        ctl_q <= ctl_wdata;
      else if (fetch_go) ctl_q <= '0;
    end
  end

  rls_fetch_ctrl #(
    .ADDR_W(ADDR_W), .NSETS(NSETS), .SET_STRIDE(SET_STRIDE),
    .NWORDS(TBL_WORDS), .WIDX_W(WIDX_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .go(fetch_go), .tbl_base(tbl_base),
    .mem_valid(mem_valid), .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
    .word_we(word_we), .word_idx(word_idx), .set_commit(set_commit)
  );

  rls_word_buf #(.NWORDS(TBL_WORDS), .WIDX_W(WIDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(word_we), .idx(word_idx),
    .wdata(mem_rdata), .flat(tb_flat)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    rls_set_regs u_set (
      .clk(clk), .rst_n(rst_n), .commit(set_commit[s]),
      .reload(ctl_snap_q[s*CTL_W +: CTL_W]), .coef_ofs(coef_ofs[s*3 +: 3]),
      .tb(tb_flat),
      .x_q(x_acc_o[s*32 +: 32]), .y_q(y_acc_o[s*32 +: 32]), .k_q(k_acc_o[s*32 +: 32]),
      .stat_q(static_o[s*NFIELD*32 +: NFIELD*32])
    );
  end
endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
  parameter int unsigned NSETS   = 2,
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned LAYER_W = 6,
  parameter int unsigned CTL_BITS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 line_start,
  input logic                 line_active,
  input logic                 blank_int,
  input logic [LAYER_W-1:0]   layer_en,
  input logic                 busy,
  input logic                 mem_req,
  input logic                 mem_valid,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [NSETS*32-1:0]  x_acc_o,
  input logic [NSETS*32-1:0]  y_acc_o,
  input logic [NSETS*32-1:0]  k_acc_o,
  input logic                 fetch_go,
  input logic [NSETS-1:0]     set_commit,
  input logic [CTL_BITS-1:0]  ctl_q,
  input logic                 ctl_we
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && line_active && !blank_int && (layer_en[4] || layer_en[5]) && !busy)
      |=> (busy && mem_req));

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !busy && (blank_int || !line_active || !(layer_en[4] || layer_en[5])))
      |=> !busy);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_ctl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !ctl_we) |=> (ctl_q == '0));

  assert_one_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_commit));

  assert_last_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_commit[NSETS-1] |=> !busy);

  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(x_acc_o) && $stable(y_acc_o) && $stable(k_acc_o)));
endmodule

bind rot_line_stepper rls_checker #(
  .NSETS(NSETS), .ADDR_W(ADDR_W), .LAYER_W(LAYER_W), .CTL_BITS(NSETS*3)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_active(line_active),
  .blank_int(blank_int), .layer_en(layer_en), .busy(busy), .mem_req(mem_req),
  .mem_valid(mem_valid), .mem_addr(mem_addr), .x_acc_o(x_acc_o), .y_acc_o(y_acc_o),
  .k_acc_o(k_acc_o), .fetch_go(fetch_go), .set_commit(set_commit), .ctl_q(ctl_q),
  .ctl_we(ctl_we)
);

// File: tb/sim_rot_line_stepper.sv
`timescale 1ns/1ps
module sim_rot_line_stepper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 0, line_active = 1, line_zero = 0, blank_int = 0;
  logic [5:0] layer_en = 6'b010000;
  logic [18:0] tbl_base = 19'h100;
  logic ctl_we = 0;
  logic [5:0] ctl_wdata = 0;
  logic [5:0] coef_ofs = 0;
  logic mem_req, mem_valid;
  logic [17:0] mem_addr;
  logic [15:0] mem_rdata;
  logic busy;
  logic [63:0] x_acc_o, y_acc_o, k_acc_o;
  logic [1279:0] static_o;

  always #5 clk = ~clk;

  rot_line_stepper u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_active(line_active),
    .line_zero(line_zero), .blank_int(blank_int), .layer_en(layer_en), .tbl_base(tbl_base),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .coef_ofs(coef_ofs), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy),
    .x_acc_o(x_acc_o), .y_acc_o(y_acc_o), .k_acc_o(k_acc_o), .static_o(static_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [15:0] mem [0:1023];
  logic [17:0] alog [0:255];
  int wcnt = 0;
  int lat = 0;

  // memory responder on falling edges, latency 0..2
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0; mem_rdata <= '0; lat <= 0;
    end else if (mem_valid) begin
      mem_valid <= 1'b0; lat <= 0;
    end else if (mem_req) begin
      if (lat >= (wcnt % 3)) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[mem_addr[9:0]];
        alog[wcnt & 255] <= mem_addr;
        wcnt <= wcnt + 1;
        lat <= 0;
      end else lat <= lat + 1;
    end
  end

  // reference model state
  logic [31:0] ex [2], ey [2], ek [2];
  logic [5:0] ctl_m = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint fld(input longint v, input int sh, input int w);
    longint u;
    u = (v >> sh) % (longint'(1) << w);
    if (u >= (longint'(1) << (w-1))) u = u - (longint'(1) << w);
    return u;
  endfunction

  function automatic longint rd32(input int a);
    return longint'(mem[a & 1023]) * 65536 + longint'(mem[(a+1) & 1023]);
  endfunction

  function automatic int rec_addr(input int s);
    return ((int'(tbl_base) & 'h7FFBE) + s*64) & 'h3FFFF;
  endfunction

  function automatic logic [31:0] exp_static(input int a, input int f);
    longint v;
    case (f)
      0:  v = fld(rd32(a + 'h04), 6, 23);
      1:  v = fld(rd32(a + 'h0A), 6, 13);
      2:  v = fld(rd32(a + 'h0C), 6, 13);
      9, 10, 11:  v = fld(longint'(mem[(a + 'h1A + f - 9) & 1023]), 0, 14);
      12, 13, 14: v = fld(longint'(mem[(a + 'h1E + f - 12) & 1023]), 0, 14);
      15: v = fld(rd32(a + 'h22), 6, 24);
      16: v = fld(rd32(a + 'h24), 6, 24);
      17: v = fld(rd32(a + 'h26), 0, 24);
      18: v = fld(rd32(a + 'h28), 0, 24);
      19: v = fld(rd32(a + 'h2E), 6, 20);
      default: v = fld(rd32(a + 'h0E + 2*(f-3)), 6, 14);
    endcase
    return v[31:0];
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) mem[i] = 16'((i * 40503 + seed * 9973) ^ (i >> 3));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #3; end
  endtask

  task automatic write_ctl(input logic [5:0] v);
    ctl_we = 1; ctl_wdata = v; step(1);
    ctl_we = 0; ctl_m = v;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin step(1); n++; end
    if (busy) chk("R10", "busy timeout", 32'(busy), 32'd0);
  endtask

  // applies one accepted line to the reference model
  task automatic model_line(input logic [5:0] snap);
    for (int s = 0; s < 2; s++) begin
      int a;
      logic [2:0] rl, ofs;
      longint kv;
      a = rec_addr(s);
      rl = snap[s*3 +: 3];
      ofs = coef_ofs[s*3 +: 3];
      ex[s] = rl[0] ? 32'(fld(rd32(a), 6, 23)) : ex[s] + 32'(fld(rd32(a + 6), 6, 13));
      ey[s] = rl[1] ? 32'(fld(rd32(a + 2), 6, 23)) : ey[s] + 32'(fld(rd32(a + 8), 6, 13));
      kv = longint'(ofs) * 64 * 1024 * 1024 + (rd32(a + 42) >> 6);
      ek[s] = rl[2] ? kv[31:0] : ek[s] + 32'(fld(rd32(a + 44), 6, 20));
    end
  endtask

  task automatic run_line(input logic lz);
    logic [5:0] snap;
    snap = lz ? 6'h3F : ctl_m;
    ctl_m = 0;
    line_start = 1; line_zero = lz; step(1);
    line_start = 0; line_zero = 0;
    chk("R10", "busy after strobe", 32'(busy), 32'd1);
    wait_idle();
    model_line(snap);
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 2; s++) begin
      chk(req, $sformatf("x set%0d", s), x_acc_o[s*32 +: 32], ex[s]);
      chk(req, $sformatf("y set%0d", s), y_acc_o[s*32 +: 32], ey[s]);
      chk(req, $sformatf("k set%0d", s), k_acc_o[s*32 +: 32], ek[s]);
      for (int f = 0; f < 20; f++)
        chk("R4", $sformatf("static set%0d f%0d", s, f),
            static_o[(s*20+f)*32 +: 32], exp_static(rec_addr(s), f));
    end
  endtask

  task automatic t_reset();  // R11
    chk("R11", "busy", 32'(busy), 0);
    chk("R11", "mem_req", 32'(mem_req), 0);
    chk("R11", "x", x_acc_o[31:0] | x_acc_o[63:32], 0);
    chk("R11", "y", y_acc_o[31:0] | y_acc_o[63:32], 0);
    chk("R11", "k", k_acc_o[31:0] | k_acc_o[63:32], 0);
    chk("R11", "static", 32'(|static_o), 0);
  endtask

  task automatic t_line_zero();  // R8
    fill(1); run_line(1'b1); check_all("R8");
  endtask

  task automatic t_advance();  // R5 R6 R7 advance path, R9 clear after line 0
    fill(7); run_line(1'b0); check_all("R5_R6_R7");
  endtask

  task automatic t_selective();  // set0 Y only, set1 X and coefficient
    fill(2); write_ctl(6'b101_010); run_line(1'b0); check_all("R6_R5_R7");
  endtask

  task automatic t_self_clear();  // R9
    fill(3); run_line(1'b0); check_all("R9");
    write_ctl(6'b000_011);
    line_start = 1; ctl_we = 1; ctl_wdata = 6'b100_000; step(1);
    line_start = 0; ctl_we = 0;
    wait_idle(); model_line(6'b000_011); ctl_m = 6'b100_000;
    check_all("R9");
    run_line(1'b0); check_all("R9");
  endtask

  task automatic t_coef_ofs();  // R7
    fill(4); coef_ofs = {3'd2, 3'd5}; write_ctl(6'b100_100); run_line(1'b0);
    check_all("R7");
    chk("R7", "k set0 top bits", {29'd0, k_acc_o[28:26]} , 32'(ek[0][28:26]));
  endtask

  task automatic t_gating();  // R1 R12
    int w0;
    w0 = wcnt;
    blank_int = 1; line_start = 1; step(1); line_start = 0; blank_int = 0;
    chk("R1", "busy blanked", 32'(busy), 0);
    layer_en = 6'b001111; line_start = 1; step(1); line_start = 0; layer_en = 6'b010000;
    chk("R1", "busy no rot layer", 32'(busy), 0);
    line_active = 0; line_start = 1; step(1); line_start = 0; line_active = 1;
    step(3);
    chk("R1", "busy inactive line", 32'(busy), 0);
    chk("R1", "no reads", 32'(wcnt - w0), 0);
    check_all("R12");
    layer_en = 6'b100000; fill(5); run_line(1'b0); layer_en = 6'b010000;
    check_all("R1");
  endtask

  task automatic t_busy_ignore();  // R10 R3
    int w0;
    w0 = wcnt; fill(6);
    line_start = 1; step(1); line_start = 0;
    step(5);
    chk("R10", "busy mid walk", 32'(busy), 1);
    line_start = 1; step(1); line_start = 0;
    wait_idle(); model_line(ctl_m); ctl_m = 0;
    step(4);
    chk("R10", "no second walk", 32'(busy), 0);
    chk("R3", "word count", 32'(wcnt - w0), 32'd96);
    check_all("R10");
  endtask

  task automatic t_addr();  // R2
    int w0;
    tbl_base = 19'h1C1; w0 = wcnt; run_line(1'b0);
    chk("R2", "set0 first", 32'(alog[w0 & 255]), 32'h180);
    chk("R2", "set0 last", 32'(alog[(w0+47) & 255]), 32'h1AF);
    chk("R2", "set1 first", 32'(alog[(w0+48) & 255]), 32'h1C0);
    check_all("R2");
    tbl_base = 19'h7FFFF; w0 = wcnt; run_line(1'b0);
    chk("R2", "hi set0 first", 32'(alog[w0 & 255]), 32'h3FFBE);
    chk("R2", "hi set1 first", 32'(alog[(w0+48) & 255]), 32'h3FFFE);
    chk("R2", "hi set1 wrap", 32'(alog[(w0+50) & 255]), 32'h00000);
    check_all("R2");
    tbl_base = 19'h100;
  endtask

  task automatic t_wrap();  // R11 R5
    fill(8);
    mem['h100] = 16'h0000; mem['h101] = 16'(3 << 6);          // X start = 3
    mem['h106] = 16'h0007; mem['h107] = 16'hFE00;            // X delta = -8
    write_ctl(6'b000_001); run_line(1'b0);
    chk("R5", "x reload", x_acc_o[31:0], 32'd3);
    run_line(1'b0);
    chk("R11", "x wrap", x_acc_o[31:0], 32'hFFFFFFFB);
    check_all("R11");
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin ex[s] = 0; ey[s] = 0; ek[s] = 0; end
    fill(0);
    step(4);
    rst_n = 1; step(1);
    t_reset();
    t_line_zero();
    t_advance();
    t_selective();
    t_self_clear();
    t_coef_ofs();
    t_gating();
    t_busy_ignore();
    t_addr();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run exceeded limit actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule